// File: doc/BRIEF.md
# Flush-to-Zero Single-Precision Adder

This block adds or subtracts two binary32 floating-point operands under a reduced rule set. There are no subnormals: a denormal input counts as a signed zero, and a tiny result becomes zero. The only rounding is round-to-nearest with ties to the even significand. The block has no flags and no traps. Each input pair yields a fully defined 32-bit result on the output alone.

Errors travel in-band. An invalid operation (two infinities of opposite effective sign) yields a quiet NaN whose low fraction bits hold an error code. A NaN that arrives on an input is passed on with its payload intact and its quiet bit set, so the origin of a fault can be traced at the end of a chain of operations. The unit is a three-stage pipeline (align, add/normalize, round/pack) that accepts one operation per cycle and has no stall.

Top module: `fpadd_core`

## Requirements
- R1: An input whose exponent field is 0 is treated as a zero of the same sign, whatever its fraction.
- R2: A result whose magnitude after rounding is below 2^-126 is output as a zero that keeps the result's sign, so the output never has exponent field 0 with a non-zero fraction.
- R3: Finite results are rounded to nearest. On an exact tie the result takes the significand whose lowest bit is 0.
- R4: A finite result whose rounded magnitude reaches 2^128 is output as infinity (exponent field all ones, fraction 0) with the result's sign.
- R5: If operand a is a NaN, the result is a with bit 22 set. If only operand b is a NaN, the result is b as given (sign not altered by subtraction) with bit 22 set. A NaN with bit 22 clear is handled the same way.
- R6: Infinities of opposite effective sign give 0x7FC00001: sign 0, quiet bit 22 set, error code 1 in the low fraction bits.
- R7: An infinity plus a finite value, or two infinities of the same effective sign, give that infinity.
- R8: An exact zero sum of operands with opposite effective signs is +0. Two zeros of equal effective sign give that zero, so -0 + -0 is -0.
- R9: out_valid equals in_valid delayed by exactly three clock cycles, and each result leaves in the order its operands entered.
- R10: While rst_n is sampled low, the pipeline empties, and out_valid is 0 on the following cycle.
- R11: With in_sub = 1 the result is in_a minus in_b. With in_sub = 0 it is in_a plus in_b.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operands on in_a/in_b are present this cycle |
| in_sub | input | 1 | 1 selects subtraction, 0 selects addition |
| in_a | input | 32 | First operand, binary32 |
| in_b | input | 32 | Second operand, binary32 |
| out_valid | output | 1 | out_result holds a result this cycle |
| out_result | output | 32 | Sum or difference, binary32 |

## Verification
The bench uses the default widths: an 8-bit exponent and a 23-bit fraction, the binary32 layout. With these widths the operands can be placed at the extremes of the exponent range. Operands near exponent 254 drive rounding into infinity. Operands close to exponent 1 cancel below the smallest normal and test the flush. A bench model works on exact wide integers, and random pairs with nearby exponents are checked against it. This mix reaches ties, large cancellations and every pairing of zero, infinity, NaN and denormal.

// File: rtl/fpadd_pkg.sv
package fpadd_pkg;
    parameter int FP_EXP_W = 8;
    parameter int FP_MAN_W = 23;
    parameter int FP_NAN_CODE_INVALID = 1;
endpackage

// File: rtl/fpadd_align.sv
module fpadd_align
    import fpadd_pkg::*;
#(
    parameter int EXP_W = FP_EXP_W,
    parameter int MAN_W = FP_MAN_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic                 in_sub,
    input  logic [EXP_W+MAN_W:0] in_a,
    input  logic [EXP_W+MAN_W:0] in_b,
    output logic                 v_o,
    output logic                 spec_o,
    output logic [EXP_W+MAN_W:0] sval_o,
    output logic                 sign_o,
    output logic                 esub_o,
    output logic [EXP_W-1:0]     exp_o,
    output logic [MAN_W+3:0]     sx_o,
    output logic [MAN_W+3:0]     sy_o
);
    localparam int W  = 1 + EXP_W + MAN_W;
    localparam int AW = MAN_W + 4;
    localparam int SW = MAN_W + 1;

    typedef struct packed {
        logic             v;
        logic             spec;
        logic [W-1:0]     sval;
        logic             sign;
        logic             esub;
        logic [EXP_W-1:0] exp;
        logic [AW-1:0]    sx;
        logic [AW-1:0]    sy;
    } s1_t;

    s1_t st_d, st_q;

    always_comb begin
        logic [EXP_W-1:0] ea, eb, ex, ey, dexp;
        logic [MAN_W-1:0] fa, fb;
        logic [SW-1:0]    siga, sigb, sigx, sigy;
        logic             sa, sb, a_zero, b_zero, a_inf, b_inf, a_nan, b_nan, swap;
        logic [W-1:0]     qnan;
        logic [2*AW-1:0]  wide;
        int unsigned      sh;

        ea = in_a[W-2:MAN_W];
        eb = in_b[W-2:MAN_W];
        fa = in_a[MAN_W-1:0];
        fb = in_b[MAN_W-1:0];
        sa = in_a[W-1];
        sb = in_b[W-1] ^ in_sub;
        a_zero = (ea == '0);
        b_zero = (eb == '0);
        a_inf  = (ea == '1) && (fa == '0);
        b_inf  = (eb == '1) && (fb == '0);
        a_nan  = (ea == '1) && (fa != '0);
        b_nan  = (eb == '1) && (fb != '0);
        siga = a_zero ? '0 : {1'b1, fa};
        sigb = b_zero ? '0 : {1'b1, fb};
        swap = {eb, sigb} > {ea, siga};
        ex   = swap ? eb : ea;
        ey   = swap ? ea : eb;
        sigx = swap ? sigb : siga;
        sigy = swap ? siga : sigb;
        dexp = ex - ey;
        sh   = (int'(dexp) > AW) ? AW : int'(dexp);
        wide = {sigy, 3'b000, {AW{1'b0}}} >> sh;

        qnan = '0;
        qnan[W-2:MAN_W]   = '1;
        qnan[MAN_W-1]     = 1'b1;
        qnan[MAN_W-2:0]   = (MAN_W-1)'(FP_NAN_CODE_INVALID);

        st_d.v    = in_valid;
        st_d.spec = 1'b1;
        st_d.sval = '0;
        if (a_nan) begin
            st_d.sval = in_a | (W'(1) << (MAN_W-1));
        end else if (b_nan) begin
            st_d.sval = in_b | (W'(1) << (MAN_W-1));
        end else if (a_inf && b_inf && (sa != sb)) begin
            st_d.sval = qnan;
        end else if (a_inf) begin
            st_d.sval = {sa, {EXP_W{1'b1}}, {MAN_W{1'b0}}};
        end else if (b_inf) begin
            st_d.sval = {sb, {EXP_W{1'b1}}, {MAN_W{1'b0}}};
        end else begin
            st_d.spec = 1'b0;
        end
        st_d.sign = swap ? sb : sa;
        st_d.esub = sa ^ sb;
        st_d.exp  = ex;
        st_d.sx   = {sigx, 3'b000};
        st_d.sy   = wide[2*AW-1:AW] | {{(AW-1){1'b0}}, |wide[AW-1:0]};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign v_o    = st_q.v;
    assign spec_o = st_q.spec;
    assign sval_o = st_q.sval;
    assign sign_o = st_q.sign;
    assign esub_o = st_q.esub;
    assign exp_o  = st_q.exp;
    assign sx_o   = st_q.sx;
    assign sy_o   = st_q.sy;
endmodule

// File: rtl/fpadd_norm.sv
module fpadd_norm
    import fpadd_pkg::*;
#(
    parameter int EXP_W = FP_EXP_W,
    parameter int MAN_W = FP_MAN_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 v_i,
    input  logic                 spec_i,
    input  logic [EXP_W+MAN_W:0] sval_i,
    input  logic                 sign_i,
    input  logic                 esub_i,
    input  logic [EXP_W-1:0]     exp_i,
    input  logic [MAN_W+3:0]     sx_i,
    input  logic [MAN_W+3:0]     sy_i,
    output logic                 v_o,
    output logic                 spec_o,
    output logic [EXP_W+MAN_W:0] sval_o,
    output logic                 sign_o,
    output logic                 zero_o,
    output logic [EXP_W+1:0]     exp_o,
    output logic [MAN_W+3:0]     nm_o
);
    localparam int W  = 1 + EXP_W + MAN_W;
    localparam int AW = MAN_W + 4;
    localparam int EW = EXP_W + 2;

    typedef struct packed {
        logic          v;
        logic          spec;
        logic [W-1:0]  sval;
        logic          sign;
        logic          zero;
        logic [EW-1:0] exp;
        logic [AW-1:0] nm;
    } s2_t;

    s2_t st_d, st_q;

    always_comb begin
        logic [AW:0] sum;
        int          lz;

        sum = esub_i ? ({1'b0, sx_i} - {1'b0, sy_i}) : ({1'b0, sx_i} + {1'b0, sy_i});
        lz  = AW;
        for (int i = 0; i < AW; i++) begin
            if (sum[i]) lz = AW - 1 - i;
        end
        st_d.v    = v_i;
        st_d.spec = spec_i;
        st_d.sval = sval_i;
        st_d.zero = (sum == '0);
        st_d.sign = st_d.zero ? (sign_i & ~esub_i) : sign_i;
        if (sum[AW]) begin
            st_d.nm  = sum[AW:1] | {{(AW-1){1'b0}}, sum[0]};
            st_d.exp = {2'b00, exp_i} + EW'(1);
        end else begin
            st_d.nm  = sum[AW-1:0] << lz;
            st_d.exp = {2'b00, exp_i} - EW'(lz);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // Stage 1 must hand over the larger magnitude first, so a subtraction never goes negative
    assert_larger_first_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (v_i && !spec_i) |-> (sx_i >= sy_i));

    assign v_o    = st_q.v;
    assign spec_o = st_q.spec;
    assign sval_o = st_q.sval;
    assign sign_o = st_q.sign;
    assign zero_o = st_q.zero;
    assign exp_o  = st_q.exp;
    assign nm_o   = st_q.nm;
endmodule

// File: rtl/fpadd_round.sv
module fpadd_round
    import fpadd_pkg::*;
#(
    parameter int EXP_W = FP_EXP_W,
    parameter int MAN_W = FP_MAN_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 v_i,
    input  logic                 spec_i,
    input  logic [EXP_W+MAN_W:0] sval_i,
    input  logic                 sign_i,
    input  logic                 zero_i,
    input  logic [EXP_W+1:0]     exp_i,
    input  logic [MAN_W+3:0]     nm_i,
    output logic                 v_o,
    output logic [EXP_W+MAN_W:0] res_o
);
    localparam int W    = 1 + EXP_W + MAN_W;
    localparam int AW   = MAN_W + 4;
    localparam int EW   = EXP_W + 2;
    localparam int EMAX = (1 << EXP_W) - 1;

    typedef struct packed {
        logic         v;
        logic [W-1:0] res;
    } s3_t;

    s3_t st_d, st_q;

    always_comb begin
        logic signed [EW-1:0] e;
        logic [MAN_W+1:0]     rm;
        logic                 inc;

        inc = nm_i[2] & (nm_i[3] | nm_i[1] | nm_i[0]);
        rm  = {1'b0, nm_i[AW-1:3]} + (MAN_W+2)'(inc);
        e   = $signed(exp_i);
        if (rm[MAN_W+1]) begin
            rm = rm >> 1;
            e  = e + EW'(1);
        end
        st_d.v = v_i;
        if (spec_i)
            st_d.res = sval_i;
        else if (zero_i || (int'(e) <= 0))
            st_d.res = {sign_i, {(W-1){1'b0}}};
        else if (int'(e) >= EMAX)
            st_d.res = {sign_i, {EXP_W{1'b1}}, {MAN_W{1'b0}}};
        else
            st_d.res = {sign_i, e[EXP_W-1:0], rm[MAN_W-1:0]};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assert_norm_msb_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (v_i && !spec_i && !zero_i) |-> nm_i[AW-1]);

    assert_no_subnormal_R2: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.v |-> !((st_q.res[W-2:MAN_W] == '0) && (st_q.res[MAN_W-1:0] != '0)));

    assert_quiet_nan_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.v && (st_q.res[W-2:MAN_W] == '1) && (st_q.res[MAN_W-1:0] != '0))
            |-> st_q.res[MAN_W-1]);

    assign v_o   = st_q.v;
    assign res_o = st_q.res;
endmodule

// File: rtl/fpadd_core.sv
module fpadd_core
    import fpadd_pkg::*;
#(
    parameter int EXP_W = FP_EXP_W,
    parameter int MAN_W = FP_MAN_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic                 in_sub,
    input  logic [EXP_W+MAN_W:0] in_a,
    input  logic [EXP_W+MAN_W:0] in_b,
    output logic                 out_valid,
    output logic [EXP_W+MAN_W:0] out_result
);
    localparam int W  = 1 + EXP_W + MAN_W;
    localparam int AW = MAN_W + 4;
    localparam int EW = EXP_W + 2;

    logic             a_v, a_spec, a_sign, a_esub;
    logic [W-1:0]     a_sval;
    logic [EXP_W-1:0] a_exp;
    logic [AW-1:0]    a_sx, a_sy;

    logic             n_v, n_spec, n_sign, n_zero;
    logic [W-1:0]     n_sval;
    logic [EW-1:0]    n_exp;
    logic [AW-1:0]    n_nm;

    fpadd_align #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_align (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sub(in_sub),
        .in_a(in_a), .in_b(in_b),
        .v_o(a_v), .spec_o(a_spec), .sval_o(a_sval), .sign_o(a_sign),
        .esub_o(a_esub), .exp_o(a_exp), .sx_o(a_sx), .sy_o(a_sy)
    );

    fpadd_norm #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_norm (
        .clk(clk), .rst_n(rst_n),
        .v_i(a_v), .spec_i(a_spec), .sval_i(a_sval), .sign_i(a_sign),
        .esub_i(a_esub), .exp_i(a_exp), .sx_i(a_sx), .sy_i(a_sy),
        .v_o(n_v), .spec_o(n_spec), .sval_o(n_sval), .sign_o(n_sign),
        .zero_o(n_zero), .exp_o(n_exp), .nm_o(n_nm)
    );

    fpadd_round #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_round (
        .clk(clk), .rst_n(rst_n),
        .v_i(n_v), .spec_i(n_spec), .sval_i(n_sval), .sign_i(n_sign),
        .zero_i(n_zero), .exp_i(n_exp), .nm_i(n_nm),
        .v_o(out_valid), .res_o(out_result)
    );

    // Cycles since reset, saturating, so the latency check never looks before reset
    logic [1:0] age_d, age_q;
    always_comb age_d = (age_q == 2'd3) ? age_q : age_q + 2'd1;
    always_ff @(posedge clk) begin
        if (!rst_n) age_q <= '0;
        else        age_q <= age_d;
    end

    assert_latency_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q == 2'd3) |-> (out_valid == $past(in_valid, 3)));

    assert_reset_empty_R10: assert property (@(posedge clk)
        !rst_n |=> !out_valid);
endmodule

// File: tb/tb_fpadd_core.sv
module tb_fpadd_core;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_sub = 1'b0;
    logic [31:0] in_a = '0;
    logic [31:0] in_b = '0;
    logic        out_valid;
    logic [31:0] out_result;

    fpadd_core dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sub(in_sub),
        .in_a(in_a), .in_b(in_b), .out_valid(out_valid), .out_result(out_result)
    );

    always #2 clk = ~clk;

    int          n_chk = 0;
    int          n_bad = 0;
    logic [31:0] exp_q [0:4095];
    string       tag_q [0:4095];
    int          wr = 0;
    int          rd = 0;
    logic [2:0]  vh = '0;
    bit          chk_en = 1'b0;

    task automatic check32(input string tag, input logic [31:0] act, input logic [31:0] expv);
        n_chk++;
        if (act !== expv) begin
            n_bad++;
            $display("FAIL %s: actual %08h expected %08h", tag, act, expv);
        end
    endtask

    // Exact model on wide integers in units of 2^-149
    function automatic logic [31:0] ref_add(input logic [31:0] a, input logic [31:0] b, input logic sub);
        logic [7:0]   ea, eb;
        logic [22:0]  fa, fb;
        logic         sa, sb, s;
        logic [299:0] ma, mb, m, rem, half;
        logic [24:0]  mant;
        int           p, sh, e;
        ea = a[30:23]; eb = b[30:23]; fa = a[22:0]; fb = b[22:0];
        sa = a[31]; sb = b[31] ^ sub;
        if (ea == 8'hFF && fa != 0) return a | 32'h0040_0000;
        if (eb == 8'hFF && fb != 0) return b | 32'h0040_0000;
        if (ea == 8'hFF && eb == 8'hFF) return (sa == sb) ? {sa, 8'hFF, 23'd0} : 32'h7FC0_0001;
        if (ea == 8'hFF) return {sa, 8'hFF, 23'd0};
        if (eb == 8'hFF) return {sb, 8'hFF, 23'd0};
        ma = (ea == 0) ? '0 : (300'({1'b1, fa}) << (ea - 1));
        mb = (eb == 0) ? '0 : (300'({1'b1, fb}) << (eb - 1));
        if (sa == sb) begin m = ma + mb; s = sa; end
        else if (ma >= mb) begin m = ma - mb; s = sa; end
        else begin m = mb - ma; s = sb; end
        if (m == 0) return (sa == sb) ? {sa, 31'd0} : 32'd0;
        p = 0;
        for (int i = 0; i < 300; i++) if (m[i]) p = i;
        if (p < 23) return {s, 31'd0};
        sh = p - 23;
        mant = 25'(m >> sh);
        rem  = m & ((300'd1 << sh) - 300'd1);
        half = (sh > 0) ? (300'd1 << (sh - 1)) : '0;
        if (sh > 0 && (rem > half || (rem == half && mant[0]))) mant = mant + 25'd1;
        e = p - 22;
        if (mant[24]) begin mant = mant >> 1; e = e + 1; end
        if (e >= 255) return {s, 8'hFF, 23'd0};
        return {s, 8'(e), mant[22:0]};
    endfunction

    function automatic string classify(input logic [31:0] a, input logic [31:0] b,
                                       input logic sub, input logic [31:0] r);
        if ((a[30:23] == 8'hFF && a[22:0] != 0) || (b[30:23] == 8'hFF && b[22:0] != 0)) return "R5";
        if (a[30:23] == 8'hFF && b[30:23] == 8'hFF && r[22:0] != 0) return "R6";
        if (a[30:23] == 8'hFF || b[30:23] == 8'hFF) return "R7";
        if (a[30:23] == 0 || b[30:23] == 0) return "R1";
        if (r[30:23] == 8'hFF) return "R4";
        if (r[30:0] == 0) return "R2";
        if (sub) return "R11";
        return "R3";
    endfunction

    task automatic step(input logic v, input logic [31:0] a, input logic [31:0] b,
                        input logic sub, input logic [31:0] expv, input string tag);
        @(negedge clk);
        if (chk_en) begin
            n_chk++;
            if (out_valid !== vh[2]) begin
                n_bad++;
                $display("FAIL R9: out_valid actual %0b expected %0b", out_valid, vh[2]);
            end
            if (out_valid === 1'b1) begin
                if (rd < wr) begin
                    check32(tag_q[rd], out_result, exp_q[rd]);
                    rd++;
                end else begin
                    n_chk++; n_bad++;
                    $display("FAIL R9: unexpected result actual %08h expected none", out_result);
                end
            end
        end
        in_valid = v; in_a = a; in_b = b; in_sub = sub;
        vh = {vh[1:0], v};
        if (v) begin
            exp_q[wr] = expv; tag_q[wr] = tag; wr++;
        end
    endtask

    task automatic dir(input logic [31:0] a, input logic [31:0] b, input logic sub,
                       input logic [31:0] expv, input string tag);
        step(1'b1, a, b, sub, expv, tag);
    endtask

    function automatic logic [31:0] pick_special(input int k, input logic [31:0] r);
        case (k % 7)
            0: return 32'h0000_0000;
            1: return 32'h8000_0000;
            2: return 32'h7F80_0000;
            3: return 32'hFF80_0000;
            4: return {r[31], 8'hFF, r[22:1], 1'b1};
            5: return {r[31], 8'h00, r[22:0]};
            default: return r;
        endcase
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL R9: watchdog expired actual hung expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] a, b, r;
        logic        s;
        int          ea, eb, cat, seed;
        seed = $urandom(32'd20240611);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check32("R10", {31'd0, out_valid}, 32'd0);
        chk_en = 1'b1;

        // R1 denormal inputs count as signed zeros
        dir(32'h0000_0001, 32'h3F80_0000, 1'b0, 32'h3F80_0000, "R1");
        dir(32'h8040_0000, 32'h0000_0005, 1'b0, 32'h0000_0000, "R1");
        dir(32'h807F_FFFF, 32'h8000_0001, 1'b0, 32'h8000_0000, "R1");
        // R2 tiny results flush with sign kept
        dir(32'h0080_0001, 32'h0080_0000, 1'b1, 32'h0000_0000, "R2");
        dir(32'h8080_0001, 32'h0080_0000, 1'b0, 32'h8000_0000, "R2");
        // R3 ties to even, and above tie
        dir(32'h3F80_0000, 32'h3380_0000, 1'b0, 32'h3F80_0000, "R3");
        dir(32'h3F80_0001, 32'h3380_0000, 1'b0, 32'h3F80_0002, "R3");
        dir(32'h3F80_0000, 32'h3380_0001, 1'b0, 32'h3F80_0001, "R3");
        // R4 overflow to signed infinity
        dir(32'h7F7F_FFFF, 32'h7F7F_FFFF, 1'b0, 32'h7F80_0000, "R4");
        dir(32'hFF7F_FFFF, 32'hFF7F_FFFF, 1'b0, 32'hFF80_0000, "R4");
        dir(32'h7F7F_FFFF, 32'h7300_0000, 1'b0, 32'h7F80_0000, "R4");
        // R5 NaN propagation
        dir(32'h7F80_0001, 32'h3F80_0000, 1'b0, 32'h7FC0_0001, "R5");
        dir(32'h3F80_0000, 32'hFFA0_0005, 1'b0, 32'hFFE0_0005, "R5");
        dir(32'h7F81_2345, 32'h7FC0_0777, 1'b0, 32'h7FC1_2345, "R5");
        dir(32'h3F80_0000, 32'h7F80_0009, 1'b1, 32'h7FC0_0009, "R5");
        // R6 invalid operation code
        dir(32'h7F80_0000, 32'hFF80_0000, 1'b0, 32'h7FC0_0001, "R6");
        dir(32'hFF80_0000, 32'hFF80_0000, 1'b1, 32'h7FC0_0001, "R6");
        // R7 infinity dominates
        dir(32'h7F80_0000, 32'h3F80_0000, 1'b0, 32'h7F80_0000, "R7");
        dir(32'h3F80_0000, 32'h7F80_0000, 1'b1, 32'hFF80_0000, "R7");
        dir(32'hFF80_0000, 32'h7F80_0000, 1'b1, 32'hFF80_0000, "R7");
        // R8 signed zeros
        dir(32'h3F80_0000, 32'h3F80_0000, 1'b1, 32'h0000_0000, "R8");
        dir(32'h8000_0000, 32'h8000_0000, 1'b0, 32'h8000_0000, "R8");
        dir(32'h8000_0000, 32'h0000_0000, 1'b0, 32'h0000_0000, "R8");
        dir(32'h8000_0000, 32'h0000_0000, 1'b1, 32'h8000_0000, "R8");
        dir(32'hBF80_0000, 32'h3F80_0000, 1'b0, 32'h0000_0000, "R8");
        // R11 subtraction select
        dir(32'h4040_0000, 32'h3F80_0000, 1'b1, 32'h4000_0000, "R11");
        dir(32'h3F80_0000, 32'h4040_0000, 1'b1, 32'hC000_0000, "R11");
        dir(32'h4040_0000, 32'h3F80_0000, 1'b0, 32'h4080_0000, "R11");

        // Random mix with gaps (R9 checked every cycle)
        for (int n = 0; n < 3000; n++) begin
            a = $urandom; b = $urandom; s = $urandom % 2;
            cat = $urandom % 8;
            ea = 1 + ($urandom % 254);
            if (cat >= 1 && cat <= 4) begin
                eb = ea + int'($urandom % 7) - 3;
                if (eb < 1) eb = 1;
                if (eb > 254) eb = 254;
                a[30:23] = 8'(ea); b[30:23] = 8'(eb);
            end else if (cat == 5) begin
                a[30:23] = 8'(1 + $urandom % 3); b[30:23] = 8'(1 + $urandom % 3);
                if ($urandom % 2 == 1) b[22:4] = a[22:4];
            end else if (cat == 6) begin
                a[30:23] = 8'(252 + $urandom % 3); b[30:23] = 8'(252 + $urandom % 3);
            end else if (cat == 7) begin
                if ($urandom % 2 == 1) a = pick_special($urandom, $urandom);
                if ($urandom % 2 == 1) b = pick_special($urandom, $urandom);
            end
            r = ref_add(a, b, s);
            if ($urandom % 6 == 0) step(1'b0, '0, '0, 1'b0, '0, "");
            step(1'b1, a, b, s, r, classify(a, b, s, r));
        end
        repeat (5) step(1'b0, '0, '0, 1'b0, '0, "");
        check32("R9", 32'(rd), 32'(wr));

        // R10 reset mid-flight empties the pipeline
        dir(32'h3F80_0000, 32'h3F80_0000, 1'b0, 32'h4000_0000, "R10");
        dir(32'h3F80_0000, 32'h3F80_0000, 1'b0, 32'h4000_0000, "R10");
        @(negedge clk);
        chk_en = 1'b0;
        rst_n = 1'b0; in_valid = 1'b0;
        @(negedge clk);
        check32("R10", {31'd0, out_valid}, 32'd0);
        @(negedge clk);
        check32("R10", {31'd0, out_valid}, 32'd0);
        rst_n = 1'b1;
        wr = 0; rd = 0; vh = '0;
        chk_en = 1'b1;
        dir(32'h4000_0000, 32'h3F80_0000, 1'b1, 32'h3F80_0000, "R11");
        repeat (5) step(1'b0, '0, '0, 1'b0, '0, "");
        check32("R9", 32'(rd), 32'(wr));

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule